// File: doc/BRIEF.md
# Interrupt Source Controller

This block holds the routing and masking state for a parameterised set of interrupt sources and turns source activity into delivery requests toward a presentation layer. Each source carries a destination server, a priority, a saved priority and four status flags. A parameter mask decides per source whether it is level-sensitive (the input follows a wire level) or message-type (the input is a one-shot event). Source `i` is known outside the block by the global number `BASE + i`. A priority of 0xFF masks a source.

A command port writes or reads a source's configuration and turns a source off or back on. The presentation layer feeds back three notifications. A reject tells the block that a delivery was refused. An end-of-interrupt tells it that a level source was serviced. A resend request makes the block walk every source in index order and offer again whatever is eligible. Deliveries leave through a valid/ready port with one request outstanding at a time. Activity that arrives while the port is busy is kept as per-source status and is not dropped.

The resend walk is a two-state machine. `S_IDLE` moves to `S_SCAN` on a resend request and starts at index 0. `S_SCAN` advances one index per cycle, but holds its index while a delivery is waiting. After the last index it either returns to `S_IDLE` or starts again from index 0, if another resend request arrived during the walk.

Top module: `isc_top`

## Requirements
- R1: After reset every source has priority 0xFF, saved priority 0xFF, server 0 and all status flags clear, and `dlv_valid` is low.
- R2: A delivery for local source `i` carries `dlv_num = BASE + i` together with that source's server and priority.
- R3: A source whose priority is 0xFF is never delivered; `dlv_prio` is never 0xFF while `dlv_valid` is high.
- R4: A message source with an event of value 1 is delivered if unmasked. If it is masked, it records a pending-while-masked flag instead. An event of value 0 has no effect.
- R5: A level source copies its event value into its asserted flag. It is delivered, and its sent flag set, only when it is unmasked, asserted and not yet sent. A repeated event of value 1 while sent produces no delivery.
- R6: A reject naming a source sets its rejected flag and clears its sent flag.
- R7: A resend request visits the sources in ascending index order. A level source applies the R5 rule. A message source with rejected set clears that flag and is delivered if unmasked. The walk holds while a delivery is waiting.
- R8: An end-of-interrupt clears the sent flag of a level source and triggers no delivery by itself. On a message source it has no effect.
- R9: Command op 0 (set) writes server, priority and saved priority. Afterwards a level source applies the R5 rule, and a message source with the pending-while-masked flag and an unmasked new priority clears that flag and is delivered.
- R10: Op 2 (off) sets priority 0xFF and stores the old priority as saved priority. Op 3 (on) writes the saved priority back as priority, with R9's follow-up rules.
- R11: A command whose number lies outside `BASE..BASE+NSRC-1`, or a set whose server is `NSERVERS` or more, returns `rsp_err = 1` and changes no source state.
- R12: While `dlv_valid` is high and `dlv_ready` is low, the delivery request stays valid and unchanged.
- R13: Every command is answered one cycle later on `rsp_valid`. Op 1 (get) returns the source's server and priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_stb | input | NSRC | Per-source input event strobe |
| ev_val | input | NSRC | Per-source input event value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set, 1 get, 2 off, 3 on |
| cmd_num | input | NUM_W | Global source number of the command |
| cmd_server | input | SRV_W | Server for set |
| cmd_prio | input | 8 | Priority for set |
| rsp_valid | output | 1 | Command response strobe |
| rsp_err | output | 1 | Command refused |
| rsp_server | output | SRV_W | Server of the named source before the command |
| rsp_prio | output | 8 | Priority of the named source before the command |
| rej_valid | input | 1 | Reject notification |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | End-of-interrupt notification |
| eoi_num | input | NUM_W | Global number serviced |
| resend_req | input | 1 | Start a resend walk |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Presentation layer accepts delivery |
| dlv_num | output | NUM_W | Global source number delivered |
| dlv_server | output | SRV_W | Destination server |
| dlv_prio | output | 8 | Delivery priority |

## Verification
On every cycle the assertions check the following. No masked priority appears on the delivery port. Delivered numbers stay inside the source window. A stalled request holds steady. The walk's index does not move while stalled. A level source's sent flag rises only when the source is asserted and unmasked. A priority changes only on a command. The flag interplay, which only the bench's scenarios can show, covers the following. Rejected message sources come back on a resend and level sources come back after end-of-interrupt. Masked message events wait for an on command. The deliveries queued behind a stalled port come out in index order.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_GET = 2'd1,
        OP_OFF = 2'd2,
        OP_ON  = 2'd3
    } isc_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_SCAN = 1'b1
    } isc_scan_e;
endpackage

// File: rtl/isc_slot.sv
module isc_slot
    import isc_pkg::*;
#(
    parameter int   SRV_W  = 4,
    parameter logic IS_LSI = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_stb,
    input  logic              ev_val,
    input  logic              cfg_we,
    input  isc_op_e           cfg_op,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              rej,
    input  logic              eoi,
    input  logic              scan_hit,
    input  logic              take,
    output logic              fire,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio
);
    logic [SRV_W-1:0]  server_q, server_d;
    logic [PRIO_W-1:0] prio_q, prio_d, saved_q, saved_d;
    logic asserted_q, asserted_d, sent_q, sent_d;
    logic rej_q, rej_d, mpend_q, mpend_d, fire_q, fire_d;

    always_comb begin
        server_d   = server_q;
        prio_d     = prio_q;
        saved_d    = saved_q;
        asserted_d = asserted_q;
        sent_d     = sent_q;
        rej_d      = rej_q;
        mpend_d    = mpend_q;
        fire_d     = fire_q;
        if (take) fire_d = 1'b0;
        if (rej) begin
            rej_d  = 1'b1;
            sent_d = 1'b0;
        end
        if (eoi && IS_LSI) sent_d = 1'b0;
        if (cfg_we) begin
            unique case (cfg_op)
                OP_SET: begin
                    server_d = cfg_server;
                    prio_d   = cfg_prio;
                    saved_d  = cfg_prio;
                end
                OP_OFF: begin
                    prio_d  = PRIO_OFF;
                    saved_d = prio_q;
                end
                OP_ON: begin
                    prio_d  = saved_q;
                    saved_d = saved_q;
                end
                default: ;
            endcase
        end
        if (IS_LSI) begin
            if (ev_stb) asserted_d = ev_val;
            if ((ev_stb || cfg_we || scan_hit) && prio_d != PRIO_OFF
                && asserted_d && !sent_d) begin
                sent_d = 1'b1;
                fire_d = 1'b1;
            end
        end else begin
            if (ev_stb && ev_val) begin
                if (prio_d == PRIO_OFF) mpend_d = 1'b1;
                else                    fire_d  = 1'b1;
            end
            if (cfg_we && mpend_d && prio_d != PRIO_OFF) begin
                mpend_d = 1'b0;
                fire_d  = 1'b1;
            end
            if (scan_hit && rej_d) begin
                rej_d = 1'b0;
                if (prio_d != PRIO_OFF) fire_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            server_q   <= '0;
            prio_q     <= PRIO_OFF;
            saved_q    <= PRIO_OFF;
            asserted_q <= 1'b0;
            sent_q     <= 1'b0;
            rej_q      <= 1'b0;
            mpend_q    <= 1'b0;
            fire_q     <= 1'b0;
        end else begin
            server_q   <= server_d;
            prio_q     <= prio_d;
            saved_q    <= saved_d;
            asserted_q <= asserted_d;
            sent_q     <= sent_d;
            rej_q      <= rej_d;
            mpend_q    <= mpend_d;
            fire_q     <= fire_d;
        end
    end

    assign fire   = fire_q;
    assign server = server_q;
    assign prio   = prio_q;

    AST_SENT_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent_q) |-> (asserted_q && prio_q != PRIO_OFF));  // R5
    AST_PRIO_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(prio_q));  // R9
endmodule

// File: rtl/isc_scan.sv
module isc_scan
    import isc_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            resend_req,
    input  logic            stall,
    output logic [NSRC-1:0] hit
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSRC - 1);

    isc_scan_e state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic again_q, again_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        again_d = again_q;
        unique case (state_q)
            S_IDLE: begin
                if (resend_req) begin
                    state_d = S_SCAN;
                    idx_d   = '0;
                    again_d = 1'b0;
                end
            end
            S_SCAN: begin
                if (resend_req) again_d = 1'b1;
                if (!stall) begin
                    if (idx_q == LAST) begin
                        idx_d = '0;
                        if (again_q || resend_req) again_d = 1'b0;
                        else                       state_d = S_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            again_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            again_q <= again_d;
        end
    end

    always_comb begin
        hit = '0;
        if (state_q == S_SCAN && !stall) hit[idx_q] = 1'b1;
    end

    AST_SCAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && stall) |=> $stable(idx_q));  // R7
    AST_SCAN_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));  // R7
endmodule

// File: rtl/isc_pick.sv
module isc_pick
    import isc_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int SRV_W = 4,
    parameter int NUM_W = 8,
    parameter int BASE  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             fire,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_a,
    input  logic [NSRC-1:0][SRV_W-1:0]  srv_a,
    output logic [NSRC-1:0]             take,
    output logic                        dlv_valid,
    input  logic                        dlv_ready,
    output logic [NUM_W-1:0]            dlv_num,
    output logic [SRV_W-1:0]            dlv_server,
    output logic [PRIO_W-1:0]           dlv_prio
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [IW-1:0] sel;
    logic any, free;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (fire[i]) begin
                sel = IW'(i);
                any = 1'b1;
            end
        end
        free = !dlv_valid || dlv_ready;
        take = '0;
        if (free && any) take[sel] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_valid  <= 1'b0;
            dlv_num    <= '0;
            dlv_server <= '0;
            dlv_prio   <= PRIO_OFF;
        end else if (free) begin
            dlv_valid <= any && (prio_a[sel] != PRIO_OFF);
            if (any) begin
                dlv_num    <= NUM_W'(BASE) + NUM_W'(sel);
                dlv_server <= srv_a[sel];
                dlv_prio   <= prio_a[sel];
            end
        end
    end

    AST_NO_MASKED_DLV: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_prio != PRIO_OFF);  // R3
    AST_DLV_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (32'(dlv_num) >= BASE && 32'(dlv_num) < BASE + NSRC));  // R2
    AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_num)
            && $stable(dlv_server) && $stable(dlv_prio)));  // R12
endmodule

// File: rtl/isc_top.sv
module isc_top
    import isc_pkg::*;
#(
    parameter int              NSRC     = 8,
    parameter int              NSERVERS = 4,
    parameter int              SRV_W    = 4,
    parameter int              NUM_W    = 8,
    parameter int              BASE     = 16,
    parameter logic [NSRC-1:0] LSI_MASK = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   ev_stb,
    input  logic [NSRC-1:0]   ev_val,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [NUM_W-1:0]  cmd_num,
    input  logic [SRV_W-1:0]  cmd_server,
    input  logic [7:0]        cmd_prio,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [SRV_W-1:0]  rsp_server,
    output logic [7:0]        rsp_prio,
    input  logic              rej_valid,
    input  logic [NUM_W-1:0]  rej_num,
    input  logic              eoi_valid,
    input  logic [NUM_W-1:0]  eoi_num,
    input  logic              resend_req,
    output logic              dlv_valid,
    input  logic              dlv_ready,
    output logic [NUM_W-1:0]  dlv_num,
    output logic [SRV_W-1:0]  dlv_server,
    output logic [7:0]        dlv_prio
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    function automatic logic in_win(input logic [NUM_W-1:0] n);
        return (32'(n) >= BASE) && (32'(n) < BASE + NSRC);
    endfunction

    function automatic logic [IW-1:0] to_idx(input logic [NUM_W-1:0] n);
        return IW'(n - NUM_W'(BASE));
    endfunction

    isc_op_e op;
    logic cmd_in, cmd_ok;
    logic [IW-1:0] cmd_idx, rej_idx, eoi_idx;
    logic [NSRC-1:0] cfg_we, rej_v, eoi_v, hit, take, fire;
    logic [NSRC-1:0][PRIO_W-1:0] prio_a;
    logic [NSRC-1:0][SRV_W-1:0]  srv_a;

    assign op      = isc_op_e'(cmd_op);
    assign cmd_in  = in_win(cmd_num);
    assign cmd_ok  = cmd_in && (op != OP_SET || 32'(cmd_server) < NSERVERS);
    assign cmd_idx = to_idx(cmd_num);
    assign rej_idx = to_idx(rej_num);
    assign eoi_idx = to_idx(eoi_num);

    always_comb begin
        cfg_we = '0;
        rej_v  = '0;
        eoi_v  = '0;
        if (cmd_valid && cmd_ok && op != OP_GET) cfg_we[cmd_idx] = 1'b1;
        if (rej_valid && in_win(rej_num))        rej_v[rej_idx]  = 1'b1;
        if (eoi_valid && in_win(eoi_num))        eoi_v[eoi_idx]  = 1'b1;
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            isc_slot #(.SRV_W(SRV_W), .IS_LSI(LSI_MASK[g])) u_slot (
                .clk(clk), .rst_n(rst_n),
                .ev_stb(ev_stb[g]), .ev_val(ev_val[g]),
                .cfg_we(cfg_we[g]), .cfg_op(op),
                .cfg_server(cmd_server), .cfg_prio(cmd_prio),
                .rej(rej_v[g]), .eoi(eoi_v[g]),
                .scan_hit(hit[g]), .take(take[g]),
                .fire(fire[g]), .server(srv_a[g]), .prio(prio_a[g])
            );
        end
    endgenerate

    isc_scan #(.NSRC(NSRC)) u_scan (
        .clk(clk), .rst_n(rst_n), .resend_req(resend_req),
        .stall(dlv_valid), .hit(hit)
    );

    isc_pick #(.NSRC(NSRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)) u_pick (
        .clk(clk), .rst_n(rst_n), .fire(fire), .prio_a(prio_a), .srv_a(srv_a),
        .take(take), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_num(dlv_num), .dlv_server(dlv_server), .dlv_prio(dlv_prio)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_server <= '0;
            rsp_prio   <= '0;
        end else begin
            rsp_valid  <= cmd_valid;
            rsp_err    <= cmd_valid && !cmd_ok;
            rsp_server <= cmd_in ? srv_a[cmd_idx] : '0;
            rsp_prio   <= cmd_in ? prio_a[cmd_idx] : '0;
        end
    end

    AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);  // R13
endmodule

// File: tb/sim_isc_top.sv
module sim_isc_top;
    localparam int NSRC = 8;
    localparam int BASE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] ev_stb = '0, ev_val = '0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [7:0] cmd_num = '0;
    logic [3:0] cmd_server = '0;
    logic [7:0] cmd_prio = '0;
    logic rsp_valid, rsp_err;
    logic [3:0] rsp_server;
    logic [7:0] rsp_prio;
    logic rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
    logic [7:0] rej_num = '0, eoi_num = '0;
    logic dlv_valid, dlv_ready = 1'b1;
    logic [7:0] dlv_num, dlv_prio;
    logic [3:0] dlv_server;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [19:0] sb[$];

    always #5 clk = ~clk;

    isc_top u0 (
        .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_val(ev_val),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
        .cmd_server(cmd_server), .cmd_prio(cmd_prio),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_server(rsp_server), .rsp_prio(rsp_prio),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num),
        .dlv_server(dlv_server), .dlv_prio(dlv_prio)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every accepted delivery
    always @(negedge clk) begin
        if (rst_n && dlv_valid && dlv_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3 unexpected delivery", {dlv_num, dlv_server, dlv_prio}, 0);
            end else begin
                logic [19:0] e;
                e = sb.pop_front();
                chk({dlv_num, dlv_server, dlv_prio} == e, "R2 delivery content",
                    {dlv_num, dlv_server, dlv_prio}, e);
            end
        end
    end

    task automatic expect_dlv(input logic [7:0] n, input logic [3:0] s, input logic [7:0] p);
        sb.push_back({n, s, p});
    endtask

    task automatic settle(input int n, input string tag);
        repeat (n) @(posedge clk);
        #1;
        chk(sb.size() == 0, tag, sb.size(), 0);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [7:0] n, input logic [3:0] s,
                       input logic [7:0] p, input bit exp_err, input string tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_num = n; cmd_server = s; cmd_prio = p;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && rsp_err == exp_err, tag, {rsp_valid, rsp_err}, {1'b1, exp_err});
        @(posedge clk); #1;
    endtask

    task automatic get(input logic [7:0] n, input logic [3:0] s, input logic [7:0] p,
                       input string tag);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_num = n;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && !rsp_err && rsp_server == s && rsp_prio == p, tag,
            {rsp_err, rsp_server, rsp_prio}, {1'b0, s, p});
        @(posedge clk); #1;
    endtask

    task automatic event_in(input int i, input logic v);
        ev_stb[i] = 1'b1; ev_val[i] = v;
        @(posedge clk); #1;
        ev_stb[i] = 1'b0;
    endtask

    task automatic pulse_rej(input logic [7:0] n);
        rej_valid = 1'b1; rej_num = n;
        @(posedge clk); #1;
        rej_valid = 1'b0;
    endtask

    task automatic pulse_eoi(input logic [7:0] n);
        eoi_valid = 1'b1; eoi_num = n;
        @(posedge clk); #1;
        eoi_valid = 1'b0;
    endtask

    task automatic pulse_resend();
        resend_req = 1'b1;
        @(posedge clk); #1;
        resend_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(dlv_valid == 1'b0, "R1 no delivery after reset", dlv_valid, 0);
        @(posedge clk); #1;
        get(8'd16, 4'd0, 8'hFF, "R1 reset priority masked");
        get(8'd23, 4'd0, 8'hFF, "R1 reset last source");
        cmd(2'd1, 8'd15, 4'd0, 8'd0, 1'b1, "R11 number below window");
        cmd(2'd1, 8'd24, 4'd0, 8'd0, 1'b1, "R11 number above window");

        // message source 0
        cmd(2'd0, 8'd16, 4'd2, 8'd5, 1'b0, "R9 set source 0");
        get(8'd16, 4'd2, 8'd5, "R13 get after set");
        expect_dlv(8'd16, 4'd2, 8'd5);
        event_in(0, 1'b1);
        settle(10, "R4 unmasked message delivered");
        event_in(0, 1'b0);
        settle(10, "R4 value zero ignored");

        // masked message source 1 waits for configuration
        event_in(1, 1'b1);
        settle(10, "R4 masked event held");
        expect_dlv(8'd17, 4'd1, 8'd3);
        cmd(2'd0, 8'd17, 4'd1, 8'd3, 1'b0, "R9 unmask source 1");
        settle(10, "R9 pending delivered on unmask");

        // bad server leaves source 2 untouched
        cmd(2'd0, 8'd18, 4'd5, 8'd4, 1'b1, "R11 server out of range");
        get(8'd18, 4'd0, 8'hFF, "R11 no change after error");

        // level source 4
        cmd(2'd0, 8'd20, 4'd3, 8'd7, 1'b0, "R9 set level source");
        expect_dlv(8'd20, 4'd3, 8'd7);
        event_in(4, 1'b1);
        settle(10, "R5 level delivered");
        event_in(4, 1'b1);
        settle(10, "R5 no repeat while sent");
        pulse_eoi(8'd20);
        settle(10, "R8 eoi alone does not deliver");
        expect_dlv(8'd20, 4'd3, 8'd7);
        pulse_resend();
        settle(20, "R8 resend after eoi redelivers level");
        pulse_rej(8'd20);
        expect_dlv(8'd20, 4'd3, 8'd7);
        pulse_resend();
        settle(20, "R6 reject clears sent of level");
        event_in(4, 1'b0);
        pulse_eoi(8'd20);
        pulse_resend();
        settle(20, "R5 deasserted level not resent");

        // message reject and resend
        pulse_rej(8'd16);
        expect_dlv(8'd16, 4'd2, 8'd5);
        pulse_resend();
        settle(20, "R7 rejected message redelivered");
        pulse_resend();
        settle(20, "R7 rejected flag cleared by resend");
        pulse_eoi(8'd16);
        pulse_resend();
        settle(20, "R8 eoi on message has no effect");

        // off / on
        cmd(2'd2, 8'd16, 4'd0, 8'd0, 1'b0, "R10 off command");
        get(8'd16, 4'd2, 8'hFF, "R10 off masks");
        event_in(0, 1'b1);
        settle(10, "R3 masked source not delivered");
        expect_dlv(8'd16, 4'd2, 8'd5);
        cmd(2'd3, 8'd16, 4'd0, 8'd0, 1'b0, "R10 on command");
        settle(10, "R10 on delivers pending event");
        get(8'd16, 4'd2, 8'd5, "R10 on restores priority");

        // stalled port, resend order
        cmd(2'd0, 8'd18, 4'd0, 8'd4, 1'b0, "R9 set source 2");
        cmd(2'd0, 8'd19, 4'd1, 8'd6, 1'b0, "R9 set source 3");
        dlv_ready = 1'b0;
        pulse_rej(8'd19);
        pulse_rej(8'd18);
        expect_dlv(8'd18, 4'd0, 8'd4);
        expect_dlv(8'd19, 4'd1, 8'd6);
        pulse_resend();
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(dlv_valid && dlv_num == 8'd18, "R12 request held while not ready",
            {dlv_valid, dlv_num}, {1'b1, 8'd18});
        @(posedge clk); #1;
        dlv_ready = 1'b1;
        settle(20, "R7 index order after stall");

        finish_run();
    end
endmodule